// File: doc/BRIEF.md
# Limit-Compare Counter Timer

This block is a register-mapped up-counter with a programmable end value and a single interrupt line. An external tick strobe advances the count by one step. The count is shown to software as a field in bits 30..9 of a 32-bit word, so each tick adds 0x200 to the value read back. When the step that follows would land on the limit, the count returns to zero instead, a sticky reached flag is set, and the interrupt rises. The counter then carries on and the cycle repeats.

Software programs the end value through one of two addresses. One restarts the count from zero and the other leaves it running. Software reads the count and the reached flag in one word. A read of the limit register doubles as the interrupt acknowledge. A stored limit of zero selects free-running operation, where the counter wraps at the largest count the field can hold. Access is single-cycle: write data is taken on the clock edge where the write strobe is high, and read data is driven combinationally from the address.

Top module: `lcc_timer`

## Requirements
- R1: After reset the limit reads 0x7FFFFE00 (count field all ones), the count reads 0, the reached flag is clear and the interrupt output is low.
- R2: The register index is address bits 4..2, so address bits 1..0 have no effect on which register is reached.
- R3: A read of index 1 returns the count in bits 30..9 and the reached flag in bit 31, with bits 8..0 always zero. Each cycle with the tick high adds 0x200 to that value.
- R4: A write to index 0 stores write-data bits 30..9 as the limit, with all other bits dropped. In the next cycle the count is zero and the interrupt is low, while the reached flag keeps its value.
- R5: A write to index 2 stores the limit with the same masking and leaves the count and the interrupt unchanged.
- R6: On a tick where count plus one equals a nonzero limit field, the count becomes zero, the reached flag is set and the interrupt is raised, all in the next cycle. Counting then goes on in the same period.
- R7: With a zero limit field, the count wraps to zero and signals reached on the tick that would make the count field all ones (0x7FFFFE00 at the default width).
- R8: A read of index 0 returns the limit in bits 30..0 with bit 31 zero. When the read strobe is high on that index, the reached flag and the interrupt are both clear in the next cycle.
- R9: When a write to index 0 or index 2 and a tick fall in the same cycle, the write takes effect and that tick is dropped.
- R10: When a reached event and an acknowledging read of index 0 fall in the same cycle, both the reached flag and the interrupt remain set afterwards.
- R11: Reads of indices 3 to 7 return zero. Writes to index 1 and to indices 3 to 7 change neither the limit, the count, the flag nor the interrupt.
- R12: If a no-restart write leaves the limit field at or below the running count, the count goes on up to the field maximum and rolls over to zero with no reached event. It then signals reached when it comes to the new limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count-advance strobe, one step per high cycle |
| bus_addr | input | 5 | Byte address; bits 4..2 select the register |
| bus_wr | input | 1 | Write strobe, data taken at the clock edge |
| bus_rd | input | 1 | Read strobe; only its effect on index 0 matters |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt, high from a reached event until acknowledge or restart |

## Verification
Read data has no register stage, so a read value belongs to the cycle in which the address is presented. The bench samples it one time step after setting the address and before the next rising edge. Every state change takes effect one edge after it is requested. This covers count steps, limit writes, restarts, reached events and acknowledges. The bench therefore drives strobes on a falling edge, lets exactly one rising edge pass, and checks count, flag and interrupt on the following falling edge. Tick bursts are held for an exact number of rising edges, so the expected count is the burst length modulo the period. A second instance with a 4-bit count field reaches the free-run wrap and the silent rollover within a few ticks.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  // register indices; their numbering is visible to software
  localparam int unsigned RIX_LIMIT      = 0;
  localparam int unsigned RIX_COUNT      = 1;
  localparam int unsigned RIX_LIMIT_KEEP = 2;

  // strobes produced by the decoder for one bus cycle
  typedef struct packed {
    logic load_restart;  // limit write that also zeroes the count
    logic load_keep;     // limit write that keeps the count
    logic ack;           // limit read, acknowledges the interrupt
  } lcc_strobe_t;

endpackage

// File: rtl/lcc_rst_sync.sv
module lcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lcc_decode.sv
module lcc_decode
  import lcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  lim_field,
  input  logic [CNT_W-1:0]  cnt_field,
  input  logic              reached,
  output lcc_strobe_t       strobe,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = ADDR_W - IDX_LSB;

  logic [IDX_W-1:0] idx;
  logic             unused_addr_bits;

  assign idx              = bus_addr[ADDR_W-1:IDX_LSB];
  assign unused_addr_bits = ^bus_addr[IDX_LSB-1:0];

  always_comb begin
    strobe              = '0;
    strobe.load_restart = bus_wr && (idx == IDX_W'(RIX_LIMIT));
    strobe.load_keep    = bus_wr && (idx == IDX_W'(RIX_LIMIT_KEEP));
    strobe.ack          = bus_rd && (idx == IDX_W'(RIX_LIMIT));
  end

  always_comb begin
    bus_rdata = '0;
    if (idx == IDX_W'(RIX_LIMIT)) begin
      bus_rdata[FRAC_W +: CNT_W] = lim_field;
    end else if (idx == IDX_W'(RIX_COUNT)) begin
      bus_rdata[FRAC_W +: CNT_W] = cnt_field;
      bus_rdata[DATA_W-1]        = reached;
    end
  end

  // R3: fraction bits of a count read are always zero
  assert_count_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'(RIX_COUNT)) |-> (bus_rdata[FRAC_W-1:0] == '0));

  // R11: undefined indices read as zero
  assert_undef_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > IDX_W'(RIX_LIMIT_KEEP)) |-> (bus_rdata == '0));

  // R8: limit read never shows bit 31
  assert_limit_msb_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'(RIX_LIMIT)) |-> !bus_rdata[DATA_W-1]);

endmodule

// File: rtl/lcc_counter.sv
module lcc_counter #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_restart,
  input  logic             load_keep,
  input  logic [CNT_W-1:0] load_value,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             wrap_ev
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim_d;
  logic [CNT_W-1:0] eff_lim;
  logic [CNT_W-1:0] cnt_inc;
  logic             load_any;
  logic             step_en;

  assign load_any = load_restart || load_keep;
  assign step_en  = tick && !load_any;
  assign eff_lim  = (lim_q == '0) ? CNT_MAX : lim_q;
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign wrap_ev  = step_en && (cnt_inc == eff_lim);

  always_comb begin
    cnt_d = cnt_q;
    if (load_restart) begin
      cnt_d = '0;
    end else if (step_en) begin
      cnt_d = wrap_ev ? '0 : cnt_inc;
    end
  end

  always_comb begin
    lim_d = lim_q;
    if (load_any) begin
      lim_d = load_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CNT_MAX;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // R4: a restarting limit write leaves a zero count
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_restart |=> (cnt_q == '0));

  // R5 and R9: a keeping limit write freezes the count for that cycle
  assert_keep_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_keep |=> (cnt_q == $past(cnt_q)));

  // R3: without tick or write the count holds
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_any) |=> $stable(cnt_q));

  // R6: count never rests on a nonzero limit after a step
  assert_never_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (lim_q != '0) && (cnt_q != lim_q)) |=> (cnt_q != $past(lim_q)));

endmodule

// File: rtl/lcc_status.sv
module lcc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_ev,
  input  logic ack,
  input  logic restart,
  output logic reached_q,
  output logic irq_q
);

  logic reached_d;
  logic irq_d;

  always_comb begin
    reached_d = reached_q;
    if (wrap_ev) begin
      reached_d = 1'b1;
    end else if (ack) begin
      reached_d = 1'b0;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (wrap_ev) begin
      irq_d = 1'b1;
    end else if (ack || restart) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      reached_q <= reached_d;
      irq_q     <= irq_d;
    end
  end

  // R6: interrupt is only ever high while the flag is set
  assert_irq_implies_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> reached_q);

  // R8: acknowledge without a competing event clears both
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap_ev) |=> (!irq_q && !reached_q));

  // R10: an event wins over a simultaneous acknowledge
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wrap_ev) |=> (irq_q && reached_q));

  // R4: restart drops the interrupt but not the flag
  assert_restart_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !ack) |=> (!irq_q && (reached_q == $past(reached_q))));

endmodule

// File: rtl/lcc_timer.sv
module lcc_timer
  import lcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned FIELD_HI = FRAC_W + CNT_W - 1;

  logic             rst_sync_n;
  lcc_strobe_t      strobe;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             wrap_ev;
  logic             reached_q;
  logic             irq_q;
  logic [CNT_W-1:0] wfield;
  logic             unused_wdata_bits;

  assign wfield            = bus_wdata[FIELD_HI:FRAC_W];
  assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:FIELD_HI+1], bus_wdata[FRAC_W-1:0]};

  lcc_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcc_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .lim_field (lim_q),
    .cnt_field (cnt_q),
    .reached   (reached_q),
    .strobe    (strobe),
    .bus_rdata (bus_rdata)
  );

  lcc_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tick         (tick),
    .load_restart (strobe.load_restart),
    .load_keep    (strobe.load_keep),
    .load_value   (wfield),
    .cnt_q        (cnt_q),
    .lim_q        (lim_q),
    .wrap_ev      (wrap_ev)
  );

  lcc_status u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wrap_ev   (wrap_ev),
    .ack       (strobe.ack),
    .restart   (strobe.load_restart),
    .reached_q (reached_q),
    .irq_q     (irq_q)
  );

  assign irq = irq_q;

  // R6: a rising interrupt always follows a tick cycle
  assert_irq_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past(tick));

  // R11: a write to an index other than 0 or 2 leaves the limit alone
  assert_undef_write_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && !strobe.load_restart && !strobe.load_keep) |=> $stable(lim_q));

endmodule

// File: tb/test_lcc_timer.sv
`timescale 1ns/1ps
module test_lcc_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick [2];
  logic [4:0]  addr [2];
  logic        wr   [2];
  logic        rd   [2];
  logic [31:0] wdata[2];
  logic [31:0] rdata[2];
  logic        irq  [2];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lcc_timer i_lcc_timer (
    .clk (clk), .rst_n (rst_n), .tick (tick[0]), .bus_addr (addr[0]),
    .bus_wr (wr[0]), .bus_rd (rd[0]), .bus_wdata (wdata[0]),
    .bus_rdata (rdata[0]), .irq (irq[0])
  );

  // narrow count field so free-run and rollover come within a few ticks
  lcc_timer #(.CNT_W (4)) i_lcc_timer_narrow (
    .clk (clk), .rst_n (rst_n), .tick (tick[1]), .bus_addr (addr[1]),
    .bus_wr (wr[1]), .bus_rd (rd[1]), .bus_wdata (wdata[1]),
    .bus_rdata (rdata[1]), .irq (irq[1])
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input int u, input logic [4:0] a, input logic [31:0] v,
                           input bit with_tick = 1'b0);
    @(negedge clk);
    addr[u] = a; wdata[u] = v; wr[u] = 1'b1; tick[u] = with_tick;
    @(negedge clk);
    wr[u] = 1'b0; tick[u] = 1'b0;
  endtask

  task automatic bus_read(input int u, input logic [4:0] a, output logic [31:0] v,
                          input bit with_tick = 1'b0);
    @(negedge clk);
    addr[u] = a; rd[u] = 1'b1; tick[u] = with_tick;
    #1 v = rdata[u];
    @(negedge clk);
    rd[u] = 1'b0; tick[u] = 1'b0;
  endtask

  task automatic peek(input int u, input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    addr[u] = a;
    #1 v = rdata[u];
  endtask

  task automatic ticks(input int u, input int n);
    @(negedge clk);
    tick[u] = 1'b1;
    repeat (n) @(negedge clk);
    tick[u] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq after reset", {31'd0, irq[0]}, 32'd0);
    peek(0, 5'h04, v); check("R1 count after reset", v, 32'h0000_0000);
    peek(0, 5'h00, v); check("R1 limit after reset", v, 32'h7FFF_FE00);
    peek(1, 5'h00, v); check("R1 narrow limit after reset", v, 32'h0000_1E00);
  endtask

  task automatic t_count;
    logic [31:0] v;
    ticks(0, 5);
    peek(0, 5'h04, v); check("R3 count after 5 ticks", v, 32'h0000_0A00);
    peek(0, 5'h07, v); check("R2 low address bits ignored", v, 32'h0000_0A00);
  endtask

  task automatic t_limit_reach;
    logic [31:0] v;
    bus_write(0, 5'h00, 32'h8000_07FF);  // field 3
    peek(0, 5'h00, v); check("R4 limit masked", v, 32'h0000_0600);
    peek(0, 5'h04, v); check("R4 count cleared", v & 32'h7FFF_FFFF, 32'd0);
    bus_read(0, 5'h00, v);
    ticks(0, 2);
    peek(0, 5'h04, v); check("R6 count before limit", v, 32'h0000_0400);
    check("R6 irq before limit", {31'd0, irq[0]}, 32'd0);
    ticks(0, 1);
    peek(0, 5'h04, v); check("R6 wrap with flag", v, 32'h8000_0000);
    check("R6 irq raised", {31'd0, irq[0]}, 32'd1);
    ticks(0, 4);
    peek(0, 5'h04, v); check("R6 periodic continuation", v, 32'h8000_0200);
  endtask

  task automatic t_ack_restart;
    logic [31:0] v;
    bus_write(0, 5'h00, 32'h0000_0600);
    check("R4 restart drops irq", {31'd0, irq[0]}, 32'd0);
    peek(0, 5'h04, v); check("R4 flag kept over restart", v, 32'h8000_0000);
    ticks(0, 3);
    check("R6 irq raised again", {31'd0, irq[0]}, 32'd1);
    bus_read(0, 5'h01, v); check("R8 limit read value", v, 32'h0000_0600);
    check("R8 irq acknowledged", {31'd0, irq[0]}, 32'd0);
    peek(0, 5'h04, v); check("R8 flag cleared", v, 32'h0000_0000);
  endtask

  task automatic t_norestart;
    logic [31:0] v;
    ticks(0, 1);
    bus_write(0, 5'h08, 32'h0000_0A00);  // field 5
    peek(0, 5'h04, v); check("R5 count kept", v, 32'h0000_0200);
    peek(0, 5'h00, v); check("R5 limit stored", v, 32'h0000_0A00);
    ticks(0, 3);
    peek(0, 5'h04, v); check("R5 count below new limit", v, 32'h0000_0800);
    ticks(0, 1);
    peek(0, 5'h04, v); check("R5 wrap at new limit", v, 32'h8000_0000);
    bus_read(0, 5'h00, v);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    bus_write(0, 5'h00, 32'h0000_1400);  // field 10
    ticks(0, 2);
    bus_write(0, 5'h08, 32'h0000_1400, 1'b1);
    peek(0, 5'h04, v); check("R9 keep write drops tick", v, 32'h0000_0400);
    bus_write(0, 5'h00, 32'h0000_1400, 1'b1);
    peek(0, 5'h04, v); check("R9 restart write drops tick", v, 32'h0000_0000);
  endtask

  task automatic t_coincide;
    logic [31:0] v;
    bus_write(0, 5'h00, 32'h0000_0600);
    ticks(0, 2);
    bus_read(0, 5'h00, v, 1'b1);
    check("R10 irq stays on coincident ack", {31'd0, irq[0]}, 32'd1);
    peek(0, 5'h04, v); check("R10 flag stays set", v, 32'h8000_0000);
    bus_read(0, 5'h00, v);
    check("R10 later ack clears", {31'd0, irq[0]}, 32'd0);
  endtask

  task automatic t_undefined;
    logic [31:0] v;
    bus_write(0, 5'h00, 32'h0000_0600);
    ticks(0, 1);
    bus_write(0, 5'h04, 32'hFFFF_FFFF);
    for (int i = 3; i < 8; i++) begin
      bus_write(0, 5'(i * 4), 32'hFFFF_FFFF);
    end
    peek(0, 5'h00, v); check("R11 limit untouched", v, 32'h0000_0600);
    peek(0, 5'h04, v); check("R11 count untouched", v, 32'h0000_0200);
    check("R11 irq untouched", {31'd0, irq[0]}, 32'd0);
    for (int i = 3; i < 8; i++) begin
      bus_read(0, 5'(i * 4), v); check("R11 undefined read zero", v, 32'd0);
    end
  endtask

  task automatic t_freerun;
    logic [31:0] v;
    bus_write(0, 5'h00, 32'h0000_0000);
    peek(0, 5'h00, v); check("R7 zero limit stored", v, 32'd0);
    ticks(0, 100);
    peek(0, 5'h04, v); check("R7 free-run passes small counts", v & 32'h7FFF_FFFF, 32'h0000_C800);
    bus_write(1, 5'h00, 32'h0000_0000);
    bus_read(1, 5'h00, v);
    ticks(1, 14);
    peek(1, 5'h04, v); check("R7 narrow count at 14", v, 32'h0000_1C00);
    check("R7 narrow no irq yet", {31'd0, irq[1]}, 32'd0);
    ticks(1, 1);
    peek(1, 5'h04, v); check("R7 narrow wrap at field max", v, 32'h8000_0000);
    check("R7 narrow irq", {31'd0, irq[1]}, 32'd1);
  endtask

  task automatic t_rollover;
    logic [31:0] v;
    bus_write(1, 5'h00, 32'h0000_1400);  // field 10
    bus_read(1, 5'h00, v);
    ticks(1, 8);
    bus_write(1, 5'h08, 32'h0000_0A00);  // field 5, below count 8
    ticks(1, 7);
    peek(1, 5'h04, v); check("R12 count reaches field max", v, 32'h0000_1E00);
    ticks(1, 1);
    peek(1, 5'h04, v); check("R12 silent rollover", v, 32'h0000_0000);
    check("R12 no irq on rollover", {31'd0, irq[1]}, 32'd0);
    ticks(1, 5);
    peek(1, 5'h04, v); check("R12 reach after rollover", v, 32'h8000_0000);
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      tick[u] = 1'b0; addr[u] = '0; wr[u] = 1'b0; rd[u] = 1'b0; wdata[u] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_limit_reach();
    t_ack_restart();
    t_norestart();
    t_priority();
    t_coincide();
    t_undefined();
    t_freerun();
    t_rollover();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule